// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Miss Classification

This unit is a read-only cache with one line per set. It sits between a requester and a slower next-level memory. The unit splits each request address into three fields: a tag, a set index and a byte offset. It then compares the stored tag of the selected line against the address tag. On a hit, it answers one cycle after accepting the request and returns the addressed byte.

On a miss, the unit requests the whole block from the next level and stalls new requests until that block arrives. It then writes the block into the line and returns the addressed byte with the hit flag low.

Every response carries a two-bit outcome code: a hit, a cold miss (the line was never filled) or a conflict miss (the line holds another block). Two running counters record hits and misses. The next-level memory can take any number of cycles to answer.

Top module: `dm_cache_lookup`

## Requirements
- R1: After a synchronous reset, `req_ready` is high, `resp_valid` and `fill_req` are low, both counters read zero, and every line is invalid, so the first access to any set is a cold miss.
- R2: The address field split is fixed. Bits [OFF_W-1:0] are the byte offset. The next IDX_W bits are the set index. The remaining upper bits are the tag. As a result, consecutive blocks map to consecutive sets, and addresses 2^(OFF_W+IDX_W) bytes apart share a set.
- R3: A request is accepted when `req_valid` and `req_ready` are both high. A hit needs a valid line whose tag equals the address tag. On a hit, the cycle after acceptance shows `resp_valid`=1, `resp_hit`=1, `resp_kind`=2'b00, and `resp_data` equal to the block byte at the offset.
- R4: On a miss, `fill_req` rises in the cycle after acceptance, with `fill_addr` equal to the request address shifted right by OFF_W. While `fill_valid` is low, `fill_req` and `fill_addr` hold and `req_ready` stays low.
- R5: A fill completes at the clock edge where `fill_req` and `fill_valid` are both high. In the cycle after that edge, the unit shows `resp_valid`=1 and `resp_hit`=0, with `resp_data` equal to byte `offset` of `fill_data` (byte i is `fill_data[8i+7:8i]`). `req_ready` is high again in that same cycle, and the fetched block stays in the line for later hits.
- R6: A miss on an invalid line reports `resp_kind`=2'b01 (cold).
- R7: A miss on a valid line whose tag differs reports `resp_kind`=2'b10 (conflict).
- R8: `hit_count` rises by one with each hit response and `miss_count` rises by one with each miss response. Neither counter changes in any other cycle.
- R9: With a 4-bit address, 2-byte blocks and 4 sets, the reads 0, 1, 13, 8, 0 give cold, hit, cold, conflict, conflict.
- R10: Alternating reads of two blocks that share a set miss as conflicts on every access after the first.
- R11: A request presented while `req_ready` is low is ignored. It produces no response and fills no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte address of the read |
| req_ready | output | 1 | Unit can accept a request |
| resp_valid | output | 1 | Response present for one cycle |
| resp_data | output | 8 | Requested byte |
| resp_hit | output | 1 | Response came from a hit |
| resp_kind | output | 2 | 00 hit, 01 cold miss, 10 conflict miss |
| fill_req | output | 1 | Block fetch outstanding |
| fill_addr | output | ADDR_W-OFF_W | Block address being fetched |
| fill_valid | input | 1 | Next level delivers the block |
| fill_data | input | 8*2^OFF_W | Fetched block, byte 0 in the low bits |
| hit_count | output | CNT_W | Running hit count |
| miss_count | output | CNT_W | Running miss count |

## Verification
- A hit answers at the first falling edge after the accepting rising edge, so the bench samples exactly there and requires that no extra cycle passed.
- A miss shows `fill_req` and `fill_addr` at that same falling edge. Its response follows the edge at which the memory model's `fill_valid` is taken, so the bench polls falling edges until `resp_valid` appears and bounds the wait.
- The counters are compared against bench tallies in the same sample as each response.
- The ignored request is judged by the absence of any response in the cycles after the real one, and by the later cold miss on its address.

// File: rtl/dm_cache_lookup.sv
module dm_cache_lookup #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic [ADDR_W-1:0]             req_addr,
  output logic                          req_ready,
  output logic                          resp_valid,
  output logic [7:0]                    resp_data,
  output logic                          resp_hit,
  output logic [1:0]                    resp_kind,
  output logic                          fill_req,
  output logic [ADDR_W-OFF_W-1:0]       fill_addr,
  input  logic                          fill_valid,
  input  logic [8*(1<<OFF_W)-1:0]       fill_data,
  output logic [CNT_W-1:0]              hit_count,
  output logic [CNT_W-1:0]              miss_count
);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;
  localparam int BLK_W = 8 * (1 << OFF_W);
  localparam logic [1:0] KIND_HIT  = 2'b00;
  localparam logic [1:0] KIND_COLD = 2'b01;
  localparam logic [1:0] KIND_CONF = 2'b10;

  logic [SETS-1:0]  line_valid;
  logic [TAG_W-1:0] line_tag  [SETS];
  logic [BLK_W-1:0] line_data [SETS];
  logic             busy;
  logic [ADDR_W-1:0] pend_addr;
  logic [1:0]       pend_kind;

  wire [OFF_W-1:0] a_off = req_addr[OFF_W-1:0];
  wire [IDX_W-1:0] a_idx = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] a_tag = req_addr[ADDR_W-1 -: TAG_W];
  wire [OFF_W-1:0] p_off = pend_addr[OFF_W-1:0];
  wire [IDX_W-1:0] p_idx = pend_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] p_tag = pend_addr[ADDR_W-1 -: TAG_W];

  wire lookup_hit = line_valid[a_idx] && (line_tag[a_idx] == a_tag);
  wire accept     = req_valid && !busy;
  wire fill_done  = busy && fill_valid;

  assign req_ready = !busy;
  assign fill_req  = busy;
  assign fill_addr = pend_addr[ADDR_W-1:OFF_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      line_valid <= '0;
      busy       <= 1'b0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_kind  <= KIND_HIT;
      resp_data  <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      pend_addr  <= '0;
      pend_kind  <= KIND_HIT;
    end else begin
      resp_valid <= 1'b0;
      if (accept) begin
        if (lookup_hit) begin
          resp_valid <= 1'b1;
          resp_hit   <= 1'b1;
          resp_kind  <= KIND_HIT;
          resp_data  <= line_data[a_idx][{a_off, 3'b000} +: 8];
          hit_count  <= hit_count + 1'b1;
        end else begin
          busy      <= 1'b1;
          pend_addr <= req_addr;
          pend_kind <= line_valid[a_idx] ? KIND_CONF : KIND_COLD;
        end
      end
      if (fill_done) begin
        line_valid[p_idx] <= 1'b1;
        busy       <= 1'b0;
        resp_valid <= 1'b1;
        resp_hit   <= 1'b0;
        resp_kind  <= pend_kind;
        resp_data  <= fill_data[{p_off, 3'b000} +: 8];
        miss_count <= miss_count + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) begin
      line_tag[p_idx]  <= p_tag;
      line_data[p_idx] <= fill_data;
    end
  end

  assert_miss_starts_fill_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !lookup_hit |=> fill_req && fill_addr == $past(req_addr[ADDR_W-1:OFF_W]));
  assert_fill_hold_R4: assert property (@(posedge clk) disable iff (rst)
    fill_req && !fill_valid |=> fill_req && $stable(fill_addr) && !req_ready);
  assert_fill_done_R5: assert property (@(posedge clk) disable iff (rst)
    fill_req && fill_valid |=> resp_valid && !resp_hit && req_ready);
  assert_hit_kind_R3: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_hit |-> resp_kind == KIND_HIT);
  assert_miss_kind_R6: assert property (@(posedge clk) disable iff (rst)
    resp_valid && !resp_hit |-> (resp_kind == KIND_COLD || resp_kind == KIND_CONF));
  assert_count_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> $stable(hit_count) && $stable(miss_count));
endmodule

// File: tb/dm_cache_lookup_test.sv
module dm_cache_lookup_test;
  localparam int FILL_LAT = 3;
  logic clk = 0, rst = 1;
  logic req_valid = 0;
  logic [3:0] req_addr = '0;
  logic req_ready, resp_valid, resp_hit, fill_req;
  logic [7:0] resp_data;
  logic [1:0] resp_kind;
  logic [2:0] fill_addr;
  logic fill_valid = 0;
  logic [15:0] fill_data = '0;
  logic [15:0] hit_count, miss_count;
  int checks = 0, failures = 0, cycles = 0, lat_cnt = 0;
  int exp_hits = 0, exp_misses = 0;

  always #5 clk = ~clk;

  dm_cache_lookup #(.ADDR_W(4), .OFF_W(1), .IDX_W(2), .CNT_W(16)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_hit(resp_hit), .resp_kind(resp_kind), .fill_req(fill_req),
    .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_data(fill_data),
    .hit_count(hit_count), .miss_count(miss_count));

  function automatic logic [7:0] mem_byte(input logic [3:0] a);
    return 8'({4'b0, a} * 8'd37 + 8'd5);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      fill_valid <= 0; lat_cnt <= 0;
    end else if (fill_valid) begin
      fill_valid <= 0;
    end else if (fill_req) begin
      if (lat_cnt == FILL_LAT - 1) begin
        fill_valid <= 1;
        fill_data  <= {mem_byte({fill_addr, 1'b1}), mem_byte({fill_addr, 1'b0})};
        lat_cnt    <= 0;
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; req_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    exp_hits = 0; exp_misses = 0;
    @(negedge clk);
    check(req_ready == 1, "R1 ready", int'(req_ready), 1);
    check(resp_valid == 0 && fill_req == 0, "R1 idle", int'(resp_valid) + int'(fill_req), 0);
    check(hit_count == 0 && miss_count == 0, "R1 counters", int'(hit_count) + int'(miss_count), 0);
  endtask

  task automatic access(input logic [3:0] a, input bit exp_hit, input logic [1:0] exp_kind,
                        input string req);
    int waits = 0;
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    if (!exp_hit) begin
      check(fill_req == 1 && req_ready == 0, {req, " R4 fill started"}, int'(fill_req), 1);
      check(fill_addr == a[3:1], {req, " R4 fill_addr"}, int'(fill_addr), int'(a[3:1]));
    end
    while (!resp_valid && waits < 100) begin
      @(negedge clk); waits++;
    end
    if (exp_hit) begin exp_hits++; check(waits == 0, {req, " R3 hit latency"}, waits, 0); end
    else exp_misses++;
    check(resp_valid == 1, {req, " response"}, int'(resp_valid), 1);
    check(resp_hit == exp_hit, {req, " hit flag"}, int'(resp_hit), int'(exp_hit));
    check(resp_kind == exp_kind, {req, " kind"}, int'(resp_kind), int'(exp_kind));
    check(resp_data == mem_byte(a), {req, " data"}, int'(resp_data), int'(mem_byte(a)));
    check(hit_count == exp_hits && miss_count == exp_misses, {req, " R8 counters"},
          int'(hit_count) * 1000 + int'(miss_count), exp_hits * 1000 + exp_misses);
    if (!exp_hit) check(req_ready == 1, {req, " R5 ready after fill"}, int'(req_ready), 1);
    @(negedge clk);
  endtask

  task automatic t_sweep();
    do_reset();
    for (int a = 0; a < 16; a++) begin
      if (a % 2 == 1) access(4'(a), 1, 2'b00, "R2 R3 sweep hit");
      else if (a < 8) access(4'(a), 0, 2'b01, "R2 R6 sweep cold");
      else access(4'(a), 0, 2'b10, "R2 R7 sweep conflict");
    end
    access(4'd15, 1, 2'b00, "R5 retained block");
  endtask

  task automatic t_trace();
    do_reset();
    access(4'd0,  0, 2'b01, "R9 addr0");
    access(4'd1,  1, 2'b00, "R9 addr1");
    access(4'd13, 0, 2'b01, "R9 addr13");
    access(4'd8,  0, 2'b10, "R9 addr8");
    access(4'd0,  0, 2'b10, "R9 addr0 again");
  endtask

  task automatic t_pingpong();
    do_reset();
    access(4'd2, 0, 2'b01, "R10 first");
    for (int i = 0; i < 6; i++)
      access((i % 2 == 0) ? 4'd11 : 4'd3, 0, 2'b10, "R10 pingpong");
  endtask

  task automatic t_ignore();
    int waits = 0;
    int extra = 0;
    do_reset();
    req_valid = 1; req_addr = 4'd2;
    @(negedge clk);
    req_addr = 4'd4;
    @(negedge clk);
    req_valid = 0;
    while (!resp_valid && waits < 100) begin @(negedge clk); waits++; end
    exp_misses++;
    check(resp_valid && resp_kind == 2'b01 && resp_data == mem_byte(4'd2), "R11 first response",
          int'(resp_data), int'(mem_byte(4'd2)));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (resp_valid) extra++;
    end
    check(extra == 0, "R11 no extra response", extra, 0);
    check(miss_count == 1 && hit_count == 0, "R11 counters", int'(miss_count), 1);
    access(4'd4, 0, 2'b01, "R11 ignored addr still cold");
    access(4'd5, 1, 2'b00, "R11 then hit");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_sweep();
    t_trace();
    t_pingpong();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule